// File: doc/BRIEF.md
# Write-Only Cipher Key Store

This block keeps four 128-bit cipher keys in internal flops and hands them to a cipher engine on request. A bus host fills a slot one 32-bit word at a time. Reading any key location returns zero, so once a key goes in, the only path out is the engine port. The host can also set two swap options, and it can read those back.

The engine drives a request strobe together with a 3-bit selector. One clock later the block returns a 128-bit key and an error flag. The key comes from one of the internal slots, from one of two fused keys (modelled as input ports), or from the key carried in the current work packet. Byte and word swapping are applied on the way out.

A soft reset clears every slot and the swap options. The soft reset, and the hard reset, are also the only moments when the fused-key enable input is sampled. The cipher, the fuse array and any DMA are outside this block.

Top module: `wo_key_store`

## Requirements
- R1: A host write with `host_addr` in 0..15 stores `host_wdata` into slot `host_addr[3:2]`, word `host_addr[1:0]`. Word 0 is key bits [31:0] and word 3 is bits [127:96]. A slot counts as valid only once all four of its words have been written since the last reset.
- R2: A host read (`host_re`) of any address in 0..15 sets `host_rdata` to zero one clock later, even when the slot holds a key.
- R3: With the swap options clear, an engine request returns a key one clock after the request. Selector values 0..3 return the matching slot when it is valid. Selector 6 returns `payload_key` as it was sampled with the request. Neither raises `key_err`.
- R4: When the latched fused-key enable is 1, selector 4 returns `fuse_key` and selector 5 returns `fuse_uniq_key`, each without error.
- R5: `fuse_en_in` is latched only on a clock where `rst_n` is low or `soft_rst` is high. At any other time, changing it has no effect. While the latched enable is 0, selectors 4 and 5 return an all-zero key with `key_err` set.
- R6: Selector 7, or a selector 0..3 that names a slot that is not valid, returns an all-zero key with `key_err` set to 1.
- R7: Address 16 is the swap register: bit 0 enables byte swap and bit 1 enables word swap. A read returns both bits in those positions, with zeros above. The register resets to 0. Writes to addresses 17..31 change nothing, and reads of those addresses return zero.
- R8: When byte swap is enabled, the byte order inside each 32-bit word of the delivered key is reversed.
- R9: When word swap is enabled, the four 32-bit words of the delivered key come out in reverse order. With both options enabled, both reversals apply, byte swap first.
- R10: A soft reset clears all four slots, their written-word marks and the swap register. It takes priority over a host write in the same clock.
- R11: `key_vld` is high for exactly one clock after each clock in which `eng_req` was high, and low otherwise. `key_out` and `key_err` keep their values between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset: clears key state and relatches the fused enable |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 5 | Host word address (0..15 keys, 16 swap register) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| fuse_en_in | input | 1 | Fused-key enable, sampled only at reset |
| fuse_key | input | 128 | Fused key |
| fuse_uniq_key | input | 128 | Fused device-unique key |
| eng_req | input | 1 | Engine key request |
| eng_sel | input | 3 | Key source selector |
| payload_key | input | 128 | Key carried with the work packet |
| key_out | output | 128 | Delivered key, registered |
| key_err | output | 1 | Requested key is unavailable |
| key_vld | output | 1 | `key_out`/`key_err` belong to the previous request |

## Verification
The properties assume that `soft_rst` and `eng_req` are never high in the same clock, so a request always reads state that was settled before the reset. The payload and fused key inputs are assumed stable only within the clock they are sampled. The bench follows these assumptions: every request, host access and soft reset goes through its own task, which drives a single operation per clock. The one exception is a test that deliberately combines a host write with a soft reset in the same clock, to cover the priority stated in R10.

// File: rtl/wo_key_store.sv
`timescale 1ns/1ps
module wo_key_store #(
  parameter int KEY_W  = 128,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              fuse_en_in,
  input  logic [KEY_W-1:0]  fuse_key,
  input  logic [KEY_W-1:0]  fuse_uniq_key,
  input  logic              eng_req,
  input  logic [2:0]        eng_sel,
  input  logic [KEY_W-1:0]  payload_key,
  output logic [KEY_W-1:0]  key_out,
  output logic              key_err,
  output logic              key_vld
);
  localparam int NSLOT = 4;
  localparam int WORDS = KEY_W / WORD_W;
  localparam int BYTES = WORD_W / 8;
  localparam int SB    = $clog2(NSLOT);
  localparam int WB    = $clog2(WORDS);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(NSLOT * WORDS);

  logic [NSLOT-1:0][KEY_W-1:0] slot_q;
  logic [NSLOT-1:0][WORDS-1:0] wmask_q;
  logic byte_sw_q, word_sw_q, fuse_en_q;
  logic [KEY_W-1:0] raw_key, bstage, fin_key;
  logic raw_ok;

  wire clr = !rst_n || soft_rst;
  wire [SB-1:0] w_slot = host_addr[WB +: SB];
  wire [WB-1:0] w_word = host_addr[WB-1:0];
  wire key_loc = host_addr < CFG_ADDR;

  always_ff @(posedge clk) begin
    if (clr) begin
      slot_q    <= '0;
      wmask_q   <= '0;
      byte_sw_q <= 1'b0;
      word_sw_q <= 1'b0;
      fuse_en_q <= fuse_en_in;
    end else if (host_we) begin
      if (key_loc) begin
        slot_q[w_slot][w_word*WORD_W +: WORD_W] <= host_wdata;
        wmask_q[w_slot][w_word] <= 1'b1;
      end else if (host_addr == CFG_ADDR) begin
        byte_sw_q <= host_wdata[0];
        word_sw_q <= host_wdata[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr)
      host_rdata <= '0;
    else if (host_re)
      host_rdata <= (host_addr == CFG_ADDR) ? {{(WORD_W-2){1'b0}}, word_sw_q, byte_sw_q} : '0;
  end

  always_comb begin
    raw_key = '0;
    raw_ok  = 1'b0;
    case (eng_sel)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        raw_key = slot_q[eng_sel[SB-1:0]];
        raw_ok  = &wmask_q[eng_sel[SB-1:0]];
      end
      3'd4: begin raw_key = fuse_key;      raw_ok = fuse_en_q; end
      3'd5: begin raw_key = fuse_uniq_key; raw_ok = fuse_en_q; end
      3'd6: begin raw_key = payload_key;   raw_ok = 1'b1;      end
      default: ;
    endcase
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign bstage[w*WORD_W + b*8 +: 8] = byte_sw_q ?
        raw_key[w*WORD_W + (BYTES-1-b)*8 +: 8] : raw_key[w*WORD_W + b*8 +: 8];
    end
    assign fin_key[w*WORD_W +: WORD_W] = word_sw_q ?
      bstage[(WORDS-1-w)*WORD_W +: WORD_W] : bstage[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_out <= '0;
      key_err <= 1'b0;
      key_vld <= 1'b0;
    end else begin
      key_vld <= eng_req;
      if (eng_req) begin
        key_out <= raw_ok ? fin_key : '0;
        key_err <= !raw_ok;
      end
    end
  end
endmodule

// File: rtl/wo_key_store_chk.sv
`timescale 1ns/1ps
module wo_key_store_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         soft_rst,
  input logic         eng_req,
  input logic [2:0]   eng_sel,
  input logic [127:0] payload_key,
  input logic [127:0] key_out,
  input logic         key_err,
  input logic         key_vld,
  input logic         fuse_en_q,
  input logic         byte_sw_q,
  input logic         word_sw_q
);
  a_r11_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> key_vld);
  a_r11_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_req |=> !key_vld);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_req |=> $stable(key_out) && $stable(key_err));
  a_r6_sel7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_sel == 3'd7 |=> key_err && key_out == '0);
  a_r6_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld && key_err |-> key_out == '0);
  a_r10_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) && !soft_rst && eng_req && eng_sel < 3'd4 |=> key_err);
  a_r5_fuse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(soft_rst) |-> $stable(fuse_en_q));
  a_r3_payload: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_sel == 3'd6 && !byte_sw_q && !word_sw_q |=>
      key_out == $past(payload_key) && !key_err);
endmodule

bind wo_key_store wo_key_store_chk u_chk (.*);

// File: tb/wo_key_store_bench.sv
`timescale 1ns/1ps
module wo_key_store_bench;
  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic host_we = 0, host_re = 0;
  logic [4:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic fuse_en_in = 1;
  logic [127:0] fuse_key = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
  logic [127:0] fuse_uniq_key = 128'h0123_4567_89AB_CDEF_1122_3344_5566_7788;
  logic eng_req = 0;
  logic [2:0] eng_sel = '0;
  logic [127:0] payload_key = 128'h00010203_04050607_08090A0B_0C0D0E0F;
  logic [127:0] key_out;
  logic key_err, key_vld;

  always #10 clk = ~clk;

  wo_key_store u_wo_key_store (.*);

  typedef struct { logic [127:0] key; logic err; int due; string req; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  logic [127:0] m_slot [4];
  logic [3:0]   m_mask [4];
  logic m_bs = 0, m_ws = 0, m_fuse = 1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [128:0] act, input logic [128:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] arrange(input logic [127:0] k, input logic bs, input logic ws);
    logic [31:0] w [4];
    logic [127:0] r;
    for (int i = 0; i < 4; i++) begin
      w[i] = k[32*i +: 32];
      if (bs) w[i] = {w[i][7:0], w[i][15:8], w[i][23:16], w[i][31:24]};
    end
    for (int i = 0; i < 4; i++) r[32*i +: 32] = ws ? w[3-i] : w[i];
    return r;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin m_slot[i] = '0; m_mask[i] = '0; end
    m_bs = 0; m_ws = 0; m_fuse = fuse_en_in;
  endtask

  task automatic hwrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    if (a < 16) begin
      m_slot[a[3:2]][32*a[1:0] +: 32] = d;
      m_mask[a[3:2]][a[1:0]] = 1'b1;
    end else if (a == 16) begin
      m_bs = d[0]; m_ws = d[1];
    end
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic hread(input logic [4:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    host_re = 1; host_addr = a;
    @(negedge clk);
    host_re = 0;
    check(host_rdata === exp, req, {97'b0, host_rdata}, {97'b0, exp});
  endtask

  task automatic issue(input logic [2:0] s, input string req);
    exp_t e;
    logic [127:0] raw;
    logic ok;
    raw = '0; ok = 0;
    if (s < 4) begin raw = m_slot[s[1:0]]; ok = &m_mask[s[1:0]]; end
    else if (s == 4) begin raw = fuse_key; ok = m_fuse; end
    else if (s == 5) begin raw = fuse_uniq_key; ok = m_fuse; end
    else if (s == 6) begin raw = payload_key; ok = 1; end
    e.key = ok ? arrange(raw, m_bs, m_ws) : '0;
    e.err = !ok;
    e.req = req;
    @(negedge clk);
    e.due = cyc + 1;
    sb.push_back(e);
    eng_req = 1; eng_sel = s;
    @(negedge clk);
    eng_req = 0;
  endtask

  task automatic do_soft(input bit with_write);
    @(negedge clk);
    soft_rst = 1;
    if (with_write) begin host_we = 1; host_addr = 5'd0; host_wdata = 32'hDEAD_BEEF; end
    model_clear();
    @(negedge clk);
    soft_rst = 0; host_we = 0;
  endtask

  task automatic fill(input int s, input logic [31:0] base);
    for (int w = 0; w < 4; w++) hwrite(5'(s*4 + w), base + 32'(w) * 32'h0101_0101);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (key_vld) begin
        if (sb.size() == 0) check(0, "R11 unexpected key_vld", 129'd1, 129'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.due, {e.req, " R11 latency"}, 129'(cyc), 129'(e.due));
          check(key_out === e.key && key_err === e.err, e.req, {key_err, key_out}, {e.err, e.key});
        end
      end else if (sb.size() != 0 && sb[0].due <= cyc) begin
        check(0, {sb[0].req, " R11 missing key_vld"}, 129'd0, 129'd1);
        void'(sb.pop_front());
      end
    end
  end

  initial begin : watchdog
    #(20ns * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stimulus
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(key_vld === 0 && key_out === '0 && key_err === 0, "R11 reset state",
          {key_err, key_out}, 129'd0);
    hread(5'd16, 32'd0, "R7 swap register reset");
    issue(3'd0, "R6 unwritten slot");
    hwrite(5'd0, 32'h1111_0000);
    hwrite(5'd1, 32'h2222_0000);
    hwrite(5'd2, 32'h3333_0000);
    issue(3'd0, "R1 partial slot invalid");
    hwrite(5'd3, 32'h4444_0000);
    issue(3'd0, "R1 full slot valid");
    fill(1, 32'hA0A1_A2A3);
    fill(2, 32'h5060_7080);
    fill(3, 32'hC3C2_C1C0);
    for (int s = 1; s < 4; s++) issue(3'(s), "R3 slot select");
    for (int a = 0; a < 16; a++) hread(5'(a), 32'd0, "R2 key location reads zero");
    issue(3'd4, "R4 fused key");
    issue(3'd5, "R4 fused unique key");
    issue(3'd6, "R3 payload key");
    payload_key = 128'hCAFE_F00D_0BAD_BEEF_1357_9BDF_2468_ACE0;
    issue(3'd6, "R3 payload key changed");
    issue(3'd7, "R6 selector 7");
    hwrite(5'd17, 32'h3);
    hread(5'd16, 32'd0, "R7 write above 16 ignored");
    hread(5'd17, 32'd0, "R7 read above 16 zero");
    hwrite(5'd16, 32'h1);
    hread(5'd16, 32'h1, "R7 byte swap bit");
    issue(3'd6, "R8 byte swap payload");
    issue(3'd2, "R8 byte swap slot");
    hwrite(5'd16, 32'h2);
    hread(5'd16, 32'h2, "R7 word swap bit");
    issue(3'd6, "R9 word swap");
    hwrite(5'd16, 32'h3);
    issue(3'd1, "R9 both swaps");
    issue(3'd7, "R6 error ignores swap");
    fuse_en_in = 0;
    repeat (2) @(negedge clk);
    issue(3'd4, "R5 enable change ignored without reset");
    do_soft(0);
    hread(5'd16, 32'd0, "R10 swap register cleared");
    issue(3'd0, "R10 slot 0 cleared");
    issue(3'd3, "R10 slot 3 cleared");
    issue(3'd4, "R5 fused disabled after relatch");
    issue(3'd5, "R5 unique disabled after relatch");
    fuse_en_in = 1;
    issue(3'd5, "R5 still disabled before reset");
    do_soft(0);
    issue(3'd5, "R5 enabled after soft reset");
    fill(0, 32'h0F0E_0D0C);
    issue(3'd0, "R1 refill after soft reset");
    hwrite(5'd1, 32'h7777_7777);
    issue(3'd0, "R1 rewrite word stays valid");
    fill(2, 32'h1234_5678);
    hwrite(5'd8, 32'h0);
    do_soft(1);
    issue(3'd0, "R10 soft reset beats write");
    issue(3'd2, "R10 slot 2 cleared");
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R11 scoreboard drained", 129'(sb.size()), 129'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule